// File: doc/BRIEF.md
# Rotating Segment Placer for Compressed Line Writes

This block decides where each compressed write-back lands inside a non-volatile memory line of sixteen 4-byte segments. A line that compresses to fewer than sixteen segments leaves free room. The placer uses that room to move each new write forward inside the line, so that the same cells are not rewritten every time. A new write to a line begins in the segment that follows the last segment of the previous write to that line. When a write runs off the top of the line, it continues from segment 0. The line's wear counter advances only on such a wrap, not on every write.

Each line keeps a small record: a compression flag, a 4-bit start offset and a 4-bit size field that holds the segment count minus one. A write request gives a line index, a segment count and a compressed flag. The block answers with a stream of segment write commands, one per clock. A read request replays the stored placement as a stream of segment addresses, one per clock, in payload order. Alongside that stream the block returns the line's compression flag and its wear count.

Top module: `seg_rotor`

## Requirements
- R1: After reset, every line holds start offset 0, size field 0 (one segment), compression flag 0 and wear count 0. A read of any line then issues the single address 0, with rd_comp 0 and rd_wear 0.
- R2: The first write to a line after reset starts at segment 0.
- R3: Every later write to a line starts at segment (previous start + previous length) mod 16.
- R4: A write that starts at segment s with length L adds one to the line's wear count when s + L > 16, and leaves the count unchanged otherwise. A write that ends exactly on segment 15 does not count.
- R5: A write accepted at a clock edge produces its first segment command in the cycle right after that edge. One command follows per cycle. Command n has seg_wr_addr = (start + n) mod 16 and seg_wr_idx = n, and seg_wr_last is 1 only on the final command.
- R6: A request with wr_req_comp = 0 always writes 16 segments, whatever wr_req_nseg holds, and is stored with compression flag 0.
- R7: A request with wr_req_comp = 1 and wr_req_nseg equal to 0 or greater than 16 is rejected. It produces no segment command and leaves the line's stored placement and wear count unchanged.
- R8: A read accepted at a clock edge issues, starting in the next cycle, one address per cycle. The addresses begin at the stored offset, continue for the stored length and wrap at 16. rd_addr_last marks the final address. rd_comp and rd_wear stay constant for the whole stream.
- R9: wr_ready and rd_ready are low on every cycle of their own stream except its last cycle. A request is taken only when its valid and ready are both high.
- R10: Writes to one line leave the placement and wear count of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req_valid | input | 1 | Write request present |
| wr_req_line | input | LIDX_W | Line index of the write |
| wr_req_nseg | input | 5 | Compressed length in segments (1..16) |
| wr_req_comp | input | 1 | 1 = compressed payload, 0 = full 16-segment line |
| wr_ready | output | 1 | Write request can be taken this cycle |
| seg_wr_valid | output | 1 | Segment write command present |
| seg_wr_line | output | LIDX_W | Line of the command |
| seg_wr_addr | output | 4 | Physical segment inside the line |
| seg_wr_idx | output | 4 | Payload segment number n |
| seg_wr_last | output | 1 | Final command of the write |
| seg_wr_comp | output | 1 | Compression flag of the write |
| rd_req_valid | input | 1 | Read request present |
| rd_req_line | input | LIDX_W | Line index of the read |
| rd_ready | output | 1 | Read request can be taken this cycle |
| rd_addr_valid | output | 1 | Read segment address present |
| rd_addr_line | output | LIDX_W | Line of the read |
| rd_addr | output | 4 | Physical segment to read |
| rd_addr_last | output | 1 | Final address of the read |
| rd_comp | output | 1 | Stored compression flag of the line |
| rd_wear | output | CNT_W | Wear count of the line |

## Verification
The assertions check on every cycle the stepping of both streams: each address is one more (mod 16) than the last, the payload index counts up from 0, and the ready signals are low mid-stream. They also check that a full-line write ends on index 15, that an invalid compressed length starts no stream, and that the read's flag and wear stay steady. Only the bench's scenarios can show where a stream starts and how long it runs. This covers the chain of start offsets across successive writes, the wrap rule that moves the wear count (including the exact-fit case), the independence of lines, and the return to segment 0 after reset.

// File: rtl/seg_rotor_pkg.sv
package seg_rotor_pkg;
  localparam int SEGS   = 16;
  localparam int SEG_W  = $clog2(SEGS);
  localparam int SIZE_W = SEG_W + 1;

  // per-line placement record: 1 + SEG_W + SEG_W bits
  typedef struct packed {
    logic             comp;
    logic [SEG_W-1:0] off;
    logic [SEG_W-1:0] szm1;
  } line_meta_t;
endpackage

// File: rtl/seg_rotor_meta.sv
module seg_rotor_meta
  import seg_rotor_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 12,
  parameter int LIDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [LIDX_W-1:0] upd_line,
  input  line_meta_t        upd_meta,
  input  logic              upd_wrap,
  input  logic [LIDX_W-1:0] a_line,
  output line_meta_t        a_meta,
  output logic              a_used,
  input  logic [LIDX_W-1:0] b_line,
  output line_meta_t        b_meta,
  output logic [CNT_W-1:0]  b_wear
);
  line_meta_t       meta_all [NUM_LINES];
  logic             used_all [NUM_LINES];
  logic [CNT_W-1:0] wear_all [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_meta_t       meta_q, meta_d;
    logic             used_q, used_d;
    logic [CNT_W-1:0] wear_q, wear_d;
    logic             hit;

    assign hit = upd_en && (upd_line == LIDX_W'(g));

    always_comb begin
      meta_d = meta_q;
      used_d = used_q;
      wear_d = wear_q;
      if (hit) begin
        meta_d = upd_meta;
        used_d = 1'b1;
        if (upd_wrap) wear_d = wear_q + CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= '0;
        used_q <= 1'b0;
        wear_q <= '0;
      end else begin
        meta_q <= meta_d;
        used_q <= used_d;
        wear_q <= wear_d;
      end
    end

    assign meta_all[g] = meta_q;
    assign used_all[g] = used_q;
    assign wear_all[g] = wear_q;
  end

  assign a_meta = meta_all[a_line];
  assign a_used = used_all[a_line];
  assign b_meta = meta_all[b_line];
  assign b_wear = wear_all[b_line];
endmodule

// File: rtl/seg_rotor_seq.sv
module seg_rotor_seq
  import seg_rotor_pkg::*;
#(
  parameter int LIDX_W = 3,
  parameter int PAY_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LIDX_W-1:0] start_line,
  input  logic [SEG_W-1:0]  start_base,
  input  logic [SEG_W-1:0]  start_cnt_m1,
  input  logic [PAY_W-1:0]  start_pay,
  output logic              ready,
  output logic              out_valid,
  output logic [LIDX_W-1:0] out_line,
  output logic [SEG_W-1:0]  out_addr,
  output logic [SEG_W-1:0]  out_idx,
  output logic              out_last,
  output logic [PAY_W-1:0]  out_pay
);
  logic              act_q, act_d;
  logic [LIDX_W-1:0] line_q, line_d;
  logic [SEG_W-1:0]  base_q, base_d;
  logic [SEG_W-1:0]  cnt_q, cnt_d;
  logic [SEG_W-1:0]  n_q, n_d;
  logic [PAY_W-1:0]  pay_q, pay_d;
  logic              last;

  assign last  = act_q && (n_q == cnt_q);
  assign ready = !act_q || last;

  always_comb begin
    act_d  = act_q;
    line_d = line_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    n_d    = n_q;
    pay_d  = pay_q;
    if (start) begin
      act_d  = 1'b1;
      line_d = start_line;
      base_d = start_base;
      cnt_d  = start_cnt_m1;
      n_d    = '0;
      pay_d  = start_pay;
    end else if (act_q) begin
      if (last) act_d = 1'b0;
      else      n_d   = n_q + SEG_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      line_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      n_q    <= '0;
      pay_q  <= '0;
    end else begin
      act_q  <= act_d;
      line_q <= line_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      n_q    <= n_d;
      pay_q  <= pay_d;
    end
  end

  // physical slot wraps naturally in SEG_W bits
  assign out_valid = act_q;
  assign out_line  = line_q;
  assign out_addr  = base_q + n_q;
  assign out_idx   = n_q;
  assign out_last  = last;
  assign out_pay   = pay_q;
endmodule

// File: rtl/seg_rotor.sv
module seg_rotor
  import seg_rotor_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 12,
  parameter int LIDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req_valid,
  input  logic [LIDX_W-1:0] wr_req_line,
  input  logic [4:0]        wr_req_nseg,
  input  logic              wr_req_comp,
  output logic              wr_ready,
  output logic              seg_wr_valid,
  output logic [LIDX_W-1:0] seg_wr_line,
  output logic [3:0]        seg_wr_addr,
  output logic [3:0]        seg_wr_idx,
  output logic              seg_wr_last,
  output logic              seg_wr_comp,
  input  logic              rd_req_valid,
  input  logic [LIDX_W-1:0] rd_req_line,
  output logic              rd_ready,
  output logic              rd_addr_valid,
  output logic [LIDX_W-1:0] rd_addr_line,
  output logic [3:0]        rd_addr,
  output logic              rd_addr_last,
  output logic              rd_comp,
  output logic [CNT_W-1:0]  rd_wear
);
  line_meta_t        a_meta, b_meta, new_meta;
  logic              a_used;
  logic [CNT_W-1:0]  b_wear;
  logic [SIZE_W-1:0] wr_len, span;
  logic [SEG_W-1:0]  wr_start;
  logic              size_ok, wr_go, wrap, rd_go;
  logic [CNT_W:0]    rd_pay;

  // write side: placement decision
  always_comb begin
    wr_len   = wr_req_comp ? wr_req_nseg : SIZE_W'(SEGS);
    size_ok  = !wr_req_comp ||
               ((wr_req_nseg != '0) && (wr_req_nseg <= SIZE_W'(SEGS)));
    wr_start = a_used ? (a_meta.off + a_meta.szm1 + SEG_W'(1)) : '0;
    span     = {1'b0, wr_start} + wr_len;
    wrap     = span > SIZE_W'(SEGS);
    new_meta.comp = wr_req_comp;
    new_meta.off  = wr_start;
    new_meta.szm1 = SEG_W'(wr_len - SIZE_W'(1));
  end

  assign wr_go = wr_req_valid && wr_ready && size_ok;
  assign rd_go = rd_req_valid && rd_ready;

  seg_rotor_meta #(
    .NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .LIDX_W(LIDX_W)
  ) u_meta (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (wr_go),
    .upd_line(wr_req_line),
    .upd_meta(new_meta),
    .upd_wrap(wrap),
    .a_line  (wr_req_line),
    .a_meta  (a_meta),
    .a_used  (a_used),
    .b_line  (rd_req_line),
    .b_meta  (b_meta),
    .b_wear  (b_wear)
  );

  seg_rotor_seq #(.LIDX_W(LIDX_W), .PAY_W(1)) u_wseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (wr_go),
    .start_line  (wr_req_line),
    .start_base  (wr_start),
    .start_cnt_m1(new_meta.szm1),
    .start_pay   (wr_req_comp),
    .ready       (wr_ready),
    .out_valid   (seg_wr_valid),
    .out_line    (seg_wr_line),
    .out_addr    (seg_wr_addr),
    .out_idx     (seg_wr_idx),
    .out_last    (seg_wr_last),
    .out_pay     (seg_wr_comp)
  );

  logic [SEG_W-1:0] rd_idx_unused;

  seg_rotor_seq #(.LIDX_W(LIDX_W), .PAY_W(CNT_W + 1)) u_rseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (rd_go),
    .start_line  (rd_req_line),
    .start_base  (b_meta.off),
    .start_cnt_m1(b_meta.szm1),
    .start_pay   ({b_meta.comp, b_wear}),
    .ready       (rd_ready),
    .out_valid   (rd_addr_valid),
    .out_line    (rd_addr_line),
    .out_addr    (rd_addr),
    .out_idx     (rd_idx_unused),
    .out_last    (rd_addr_last),
    .out_pay     (rd_pay)
  );

  assign rd_comp = rd_pay[CNT_W];
  assign rd_wear = rd_pay[CNT_W-1:0];

  logic unused_ok;
  assign unused_ok = &{1'b0, rd_idx_unused};
endmodule

// File: rtl/seg_rotor_chk.sv
module seg_rotor_chk #(
  parameter int LIDX_W = 3,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req_valid,
  input logic              wr_req_comp,
  input logic [4:0]        wr_req_nseg,
  input logic              wr_ready,
  input logic              seg_wr_valid,
  input logic [3:0]        seg_wr_addr,
  input logic [3:0]        seg_wr_idx,
  input logic              seg_wr_last,
  input logic              seg_wr_comp,
  input logic              rd_ready,
  input logic              rd_addr_valid,
  input logic [3:0]        rd_addr,
  input logic              rd_addr_last,
  input logic [LIDX_W-1:0] rd_addr_line,
  input logic [CNT_W-1:0]  rd_wear,
  input logic              rd_comp
);
  assert_wr_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_valid && !seg_wr_last |=> seg_wr_valid && (seg_wr_addr == $past(seg_wr_addr) + 4'd1));

  assert_wr_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_valid && !seg_wr_last |=> seg_wr_idx == $past(seg_wr_idx) + 4'd1);

  assert_wr_idx_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_valid && seg_wr_last |=> !seg_wr_valid || (seg_wr_idx == 4'd0));

  assert_wr_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_valid && !seg_wr_last |-> !wr_ready);

  assert_full_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_valid && seg_wr_last && !seg_wr_comp |-> seg_wr_idx == 4'd15);

  assert_bad_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid && wr_ready && wr_req_comp && ((wr_req_nseg == 5'd0) || (wr_req_nseg > 5'd16))
    |=> !seg_wr_valid);

  assert_rd_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_valid && !rd_addr_last |=> rd_addr_valid && (rd_addr == $past(rd_addr) + 4'd1));

  assert_rd_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_valid && !rd_addr_last |=> $stable(rd_wear) && $stable(rd_comp) && $stable(rd_addr_line));

  assert_rd_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_valid && !rd_addr_last |-> !rd_ready);
endmodule

bind seg_rotor seg_rotor_chk #(.LIDX_W(LIDX_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_req_valid (wr_req_valid),
  .wr_req_comp  (wr_req_comp),
  .wr_req_nseg  (wr_req_nseg),
  .wr_ready     (wr_ready),
  .seg_wr_valid (seg_wr_valid),
  .seg_wr_addr  (seg_wr_addr),
  .seg_wr_idx   (seg_wr_idx),
  .seg_wr_last  (seg_wr_last),
  .seg_wr_comp  (seg_wr_comp),
  .rd_ready     (rd_ready),
  .rd_addr_valid(rd_addr_valid),
  .rd_addr      (rd_addr),
  .rd_addr_last (rd_addr_last),
  .rd_addr_line (rd_addr_line),
  .rd_wear      (rd_wear),
  .rd_comp      (rd_comp)
);

// File: tb/seg_rotor_bench.sv
`timescale 1ns/100ps
module seg_rotor_bench;
  localparam int LW = 3;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_req_valid, wr_req_comp;
  logic [LW-1:0] wr_req_line;
  logic [4:0]    wr_req_nseg;
  logic          wr_ready;
  logic          seg_wr_valid, seg_wr_last, seg_wr_comp;
  logic [LW-1:0] seg_wr_line;
  logic [3:0]    seg_wr_addr, seg_wr_idx;
  logic          rd_req_valid;
  logic [LW-1:0] rd_req_line;
  logic          rd_ready, rd_addr_valid, rd_addr_last, rd_comp;
  logic [LW-1:0] rd_addr_line;
  logic [3:0]    rd_addr;
  logic [CW-1:0] rd_wear;

  always #2.5 clk = ~clk;

  seg_rotor #(.NUM_LINES(8), .CNT_W(CW)) u_seg_rotor (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input int line, input bit comp, input int nseg,
                          input int exp_start, input int exp_len, input string tag);
    @(negedge clk);
    wr_req_valid = 1'b1; wr_req_line = LW'(line);
    wr_req_comp = comp;  wr_req_nseg = 5'(nseg);
    @(negedge clk);
    wr_req_valid = 1'b0;
    for (int n = 0; n < exp_len; n++) begin
      chk(seg_wr_valid, "R5 valid", int'(seg_wr_valid), 1);
      chk(int'(seg_wr_addr) == (exp_start + n) % 16, {tag, " addr"}, int'(seg_wr_addr), (exp_start + n) % 16);
      chk(int'(seg_wr_idx) == n, "R5 idx", int'(seg_wr_idx), n);
      chk(seg_wr_last == (n == exp_len - 1), "R5 last", int'(seg_wr_last), int'(n == exp_len - 1));
      chk(int'(seg_wr_line) == line, "R10 line", int'(seg_wr_line), line);
      chk(seg_wr_comp == comp, "R6 comp", int'(seg_wr_comp), int'(comp));
      if (n == 0 && exp_len > 1) chk(!wr_ready, "R9 ready", int'(wr_ready), 0);
      @(negedge clk);
    end
    chk(!seg_wr_valid, "R5 end", int'(seg_wr_valid), 0);
  endtask

  task automatic do_read(input int line, input int exp_start, input int exp_len,
                         input bit exp_comp, input int exp_wear, input string tag);
    @(negedge clk);
    rd_req_valid = 1'b1; rd_req_line = LW'(line);
    @(negedge clk);
    rd_req_valid = 1'b0;
    for (int n = 0; n < exp_len; n++) begin
      chk(rd_addr_valid, {tag, " R8 valid"}, int'(rd_addr_valid), 1);
      chk(int'(rd_addr) == (exp_start + n) % 16, {tag, " R8 addr"}, int'(rd_addr), (exp_start + n) % 16);
      chk(rd_addr_last == (n == exp_len - 1), {tag, " R8 last"}, int'(rd_addr_last), int'(n == exp_len - 1));
      chk(rd_comp == exp_comp, {tag, " R8 comp"}, int'(rd_comp), int'(exp_comp));
      chk(int'(rd_wear) == exp_wear, {tag, " R4 wear"}, int'(rd_wear), exp_wear);
      if (n == 0 && exp_len > 1) chk(!rd_ready, "R9 rd_ready", int'(rd_ready), 0);
      @(negedge clk);
    end
    chk(!rd_addr_valid, {tag, " R8 end"}, int'(rd_addr_valid), 0);
  endtask

  // vectors: line, comp, nseg, expected start, expected length, expected wear after, tag
  localparam int NV = 11;
  localparam int V_LINE [NV] = '{2, 2, 2, 2, 2, 2, 2, 2, 2, 5, 5};
  localparam int V_COMP [NV] = '{1, 1, 1, 1, 1, 1, 0, 1, 1, 0, 0};
  localparam int V_NSEG [NV] = '{7, 5, 6, 4, 10, 3, 3, 16, 1, 0, 20};
  localparam int V_STRT [NV] = '{0, 7, 12, 2, 6, 0, 3, 3, 3, 0, 0};
  localparam int V_LEN  [NV] = '{7, 5, 6, 4, 10, 3, 16, 16, 1, 16, 16};
  localparam int V_WEAR [NV] = '{0, 0, 1, 1, 1, 1, 2, 3, 3, 0, 0};
  localparam int V_TAG  [NV] = '{2, 3, 3, 3, 3, 3, 6, 3, 3, 6, 6};

  initial begin
    rst_n = 1'b0;
    wr_req_valid = 1'b0; wr_req_line = '0; wr_req_nseg = '0; wr_req_comp = 1'b0;
    rd_req_valid = 1'b0; rd_req_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(wr_ready && rd_ready, "R1 ready", int'(wr_ready && rd_ready), 1);
    chk(!seg_wr_valid && !rd_addr_valid, "R1 idle", int'(seg_wr_valid || rd_addr_valid), 0);
    do_read(0, 0, 1, 1'b0, 0, "R1");
    do_read(7, 0, 1, 1'b0, 0, "R1");

    for (int v = 0; v < NV; v++) begin
      do_write(V_LINE[v], V_COMP[v] != 0, V_NSEG[v], V_STRT[v], V_LEN[v], $sformatf("R%0d", V_TAG[v]));
      do_read(V_LINE[v], V_STRT[v], V_LEN[v], V_COMP[v] != 0, V_WEAR[v], "vec");
    end

    // R10: line 2 untouched by writes to line 5
    do_read(2, 3, 1, 1'b1, 3, "R10");

    // R7: invalid compressed sizes are rejected
    @(negedge clk);
    wr_req_valid = 1'b1; wr_req_line = 3'd2; wr_req_comp = 1'b1; wr_req_nseg = 5'd0;
    @(negedge clk);
    chk(!seg_wr_valid, "R7 size0", int'(seg_wr_valid), 0);
    wr_req_nseg = 5'd17;
    @(negedge clk);
    wr_req_valid = 1'b0;
    chk(!seg_wr_valid, "R7 size17", int'(seg_wr_valid), 0);
    @(negedge clk);
    chk(!seg_wr_valid, "R7 idle", int'(seg_wr_valid), 0);
    do_read(2, 3, 1, 1'b1, 3, "R7");
    // next valid write still chains from the unchanged record
    do_write(2, 1'b1, 14, 4, 14, "R3");
    do_read(2, 4, 14, 1'b1, 4, "R4");

    // R1 / R2: reset clears placement and wear, next write starts at 0
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_read(2, 0, 1, 1'b0, 0, "R1");
    do_write(2, 1'b1, 4, 0, 4, "R2");
    do_read(2, 0, 4, 1'b1, 0, "R2");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule